// File: doc/BRIEF.md
# Multi-Channel Interrupt Register Bank

This block gathers interrupt events from up to 32 hardware channels and presents them to software through four one-bit-per-channel registers: a sticky status register, an enable register, a mask register and a derived pending register. Bit k of every register belongs to channel k. A hardware event pulse latches the channel's status bit. Software clears status bits by writing ones to them.

The enable and mask registers act as opposite gates. The parameter `MASK_WINS` decides which gate has the final say. When `MASK_WINS` is 1, a set mask bit always blocks its channel. When `MASK_WINS` is 0, a set enable bit lets the channel through even if it is masked.

The single interrupt line is the registered OR of all pending bits. Software reaches the registers through a plain read/write port with a two-bit register select. Read data is registered.

Top module: `irq_regbank`

## Requirements
- R1: While `rst` is high and right after it falls, status and enable are all zeros, mask is all ones, `irq_o` is 0 and `rdata_o` is 0.
- R2: `addr_i` selects a register: 0 status, 1 enable, 2 mask, 3 pending. A read with `rd_en_i` high at a clock edge puts the selected register's value on `rdata_o` after that edge, and the value is held until the next read.
- R3: A 1 on bit k of `evt_i` at a clock edge sets status bit k at that edge.
- R4: A write to address 0 clears every status bit whose `wdata_i` bit is 1 and leaves every bit whose `wdata_i` bit is 0 unchanged.
- R5: When an event and a write-one-to-clear reach the same status bit at the same edge, the bit ends up set.
- R6: Writes to address 1 or 2 load enable or mask with `wdata_i`, and both read back unchanged.
- R7: With `MASK_WINS`=1, pending equals status AND enable AND NOT mask.
- R8: With `MASK_WINS`=0, pending equals status AND (enable OR NOT mask).
- R9: A write to address 3 changes no register: status, enable, mask and pending keep their values.
- R10: `irq_o` is 1 exactly when some pending bit was 1 before the previous clock edge, so it follows pending with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_CH | Per-channel event pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | NUM_CH | Write data |
| rdata_o | output | NUM_CH | Registered read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
On every cycle, the assertions check the following: events latch their status bits, write-one-to-clear removes only the written bits unless an event hits the same bit, the enable and mask registers load and hold correctly, writes to the pending address leave enable and mask untouched, the chosen priority rule holds for the mask, and the interrupt line follows pending one cycle later. Other behaviours can only be shown by the bench's scenarios. These are the register-select encoding and read latency, the reset values seen through the read port, and the exact pending values under both priority settings. For the priority values, the bench drives one instance per setting and compares each against pending values it computes from the register contents it has written.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_PEND   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] q_o
);
  logic [NUM_CH-1:0] q_next;

  // a set on the same bit overrides the clear, so no event is dropped
  assign q_next = (q_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= q_next;
  end

  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R5: bits both set and cleared are covered by the set check above
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/irq_rw_reg.sv
module irq_rw_reg #(
  parameter int             W       = 32,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= RST_VAL;
    else if (wr_i) q_o <= d_i;
  end

  assert_rw_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (q_o == $past(d_i)));

  assert_rw_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int NUM_CH    = 32,
  parameter bit MASK_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] status_i,
  input  logic [NUM_CH-1:0] enable_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] gate;

  generate
    if (MASK_WINS) begin : g_mask_first
      assign gate = enable_i & ~mask_i;
      assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        ((pend_o & mask_i) == '0));
    end else begin : g_enable_first
      assign gate = enable_i | ~mask_i;
      assert_enable_overrides_R8: assert property (@(posedge clk) disable iff (rst)
        ((pend_o & enable_i) == (status_i & enable_i)));
    end
  endgenerate

  assign pend_o = status_i & gate;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |pend_o;
  end

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_o != '0) |=> irq_o);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_o == '0) |=> !irq_o);
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_regbank_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [NUM_CH-1:0] status_i,
  input  logic [NUM_CH-1:0] enable_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] rdata_o
);
  logic [NUM_CH-1:0] sel_val;

  always_comb begin
    case (addr_i)
      SEL_STATUS: sel_val = status_i;
      SEL_ENABLE: sel_val = enable_i;
      SEL_MASK:   sel_val = mask_i;
      SEL_PEND:   sel_val = pend_i;
      default:    sel_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= sel_val;
  end

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter bit MASK_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [NUM_CH-1:0] MASK_RST = {NUM_CH{1'b1}};

  logic              wr_status, wr_enable, wr_mask, wr_pend;
  logic [NUM_CH-1:0] clr_bits;
  logic [NUM_CH-1:0] status_q, enable_q, mask_q, pend_w;

  assign wr_status = wr_en_i && (addr_i == SEL_STATUS);
  assign wr_enable = wr_en_i && (addr_i == SEL_ENABLE);
  assign wr_mask   = wr_en_i && (addr_i == SEL_MASK);
  assign wr_pend   = wr_en_i && (addr_i == SEL_PEND);
  assign clr_bits  = wr_status ? wdata_i : '0;

  irq_status_bank #(.NUM_CH(NUM_CH)) u_status (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(clr_bits), .q_o(status_q)
  );

  irq_rw_reg #(.W(NUM_CH), .RST_VAL('0)) u_enable (
    .clk(clk), .rst(rst), .wr_i(wr_enable), .d_i(wdata_i), .q_o(enable_q)
  );

  irq_rw_reg #(.W(NUM_CH), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst(rst), .wr_i(wr_mask), .d_i(wdata_i), .q_o(mask_q)
  );

  irq_pend_unit #(.NUM_CH(NUM_CH), .MASK_WINS(MASK_WINS)) u_pend (
    .clk(clk), .rst(rst), .status_i(status_q), .enable_i(enable_q),
    .mask_i(mask_q), .pend_o(pend_w), .irq_o(irq_o)
  );

  irq_read_port #(.NUM_CH(NUM_CH)) u_read (
    .clk(clk), .rst(rst), .rd_i(rd_en_i), .addr_i(addr_i),
    .status_i(status_q), .enable_i(enable_q), .mask_i(mask_q),
    .pend_i(pend_w), .rdata_o(rdata_o)
  );

  assert_pend_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> ($stable(enable_q) && $stable(mask_q) &&
                 ((status_q & $past(status_q)) == $past(status_q))));
endmodule

// File: tb/irq_regbank_bench.sv
module irq_regbank_bench;
  localparam int NCH = 32;

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  logic           wr_en, rd_en;
  logic [1:0]     addr;
  logic [NCH-1:0] wdata, evt;
  logic [NCH-1:0] rdata_a, rdata_b;
  logic           irq_a, irq_b;

  int checks = 0;
  int fails  = 0;

  logic [NCH-1:0] m_st, m_en, m_mk;

  irq_regbank #(.NUM_CH(NCH), .MASK_WINS(1'b1)) u_irq_regbank (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_a), .irq_o(irq_a)
  );

  irq_regbank #(.NUM_CH(NCH), .MASK_WINS(1'b0)) u_irq_regbank_alt (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_b), .irq_o(irq_b)
  );

  function automatic logic [NCH-1:0] pend_of(bit mw);
    return mw ? (m_st & m_en & ~m_mk) : (m_st & (m_en | ~m_mk));
  endfunction

  function automatic logic [NCH-1:0] model_reg(logic [1:0] a, bit mw);
    case (a)
      2'd0:    return m_st;
      2'd1:    return m_en;
      2'd2:    return m_mk;
      default: return pend_of(mw);
    endcase
  endfunction

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic cycle(logic w, logic r, logic [1:0] a, logic [NCH-1:0] d,
                       logic [NCH-1:0] e);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; evt = e;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0; evt = '0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [NCH-1:0] d, logic [NCH-1:0] e);
    cycle(1'b1, 1'b0, a, d, e);
    if (a == 2'd0) m_st = (m_st & ~d) | e;
    else           m_st = m_st | e;
    if (a == 2'd1) m_en = d;
    if (a == 2'd2) m_mk = d;
  endtask

  task automatic rd_chk(logic [1:0] a, string req);
    cycle(1'b0, 1'b1, a, '0, '0);
    check({req, " mask-first"},   rdata_a, model_reg(a, 1'b1));
    check({req, " enable-first"}, rdata_b, model_reg(a, 1'b0));
  endtask

  task automatic t_reset;
    m_st = '0; m_en = '0; m_mk = '1;
    check("R1 rdata after reset", rdata_a, '0);
    check("R1 irq after reset", {31'd0, irq_a | irq_b}, '0);
    for (int i = 0; i < 4; i++) rd_chk(i[1:0], "R1 R2 reset value");
  endtask

  task automatic t_rw;
    wr_reg(2'd1, 32'hA5A5_F00F, '0);
    wr_reg(2'd2, 32'h0F0F_00FF, '0);
    rd_chk(2'd1, "R6 enable readback");
    rd_chk(2'd2, "R6 mask readback");
    cycle(1'b0, 1'b0, 2'd0, '0, '0);
    check("R2 rdata held without read", rdata_a, m_mk);
  endtask

  task automatic t_event;
    wr_reg(2'd1, 32'h0000_0010, '0);
    wr_reg(2'd2, 32'h0000_0000, '0);
    check("R10 irq idle", {31'd0, irq_a}, '0);
    cycle(1'b0, 1'b0, 2'd0, '0, 32'h0000_0013);
    m_st = m_st | 32'h0000_0013;
    check("R10 irq one cycle late", {31'd0, irq_a}, '0);
    @(negedge clk);
    check("R10 irq raised", {31'd0, irq_a}, 32'd1);
    rd_chk(2'd0, "R3 status after event");
    rd_chk(2'd3, "R7 R8 pending after event");
  endtask

  task automatic t_w1c;
    wr_reg(2'd0, 32'h0000_0001, '0);
    rd_chk(2'd0, "R4 clear bit0 keeps others");
    wr_reg(2'd0, 32'h0000_0000, '0);
    rd_chk(2'd0, "R4 zero write no change");
    wr_reg(2'd0, 32'h0000_0012, 32'h0000_0010);
    rd_chk(2'd0, "R5 set wins over clear");
    check("R5 bit4 kept", rdata_a & 32'h10, 32'h10);
    wr_reg(2'd0, 32'h0000_0010, '0);
    rd_chk(2'd0, "R4 clear bit4");
    @(negedge clk);
    check("R10 irq dropped", {31'd0, irq_a}, '0);
  endtask

  task automatic t_pend_ro;
    wr_reg(2'd1, 32'h0000_00F0, 32'h0000_0030);
    wr_reg(2'd3, 32'hFFFF_FFFF, '0);
    rd_chk(2'd0, "R9 status unchanged");
    rd_chk(2'd1, "R9 enable unchanged");
    rd_chk(2'd2, "R9 mask unchanged");
    rd_chk(2'd3, "R9 pending unchanged");
  endtask

  task automatic t_priority;
    wr_reg(2'd0, '0, 32'hFFFF_FFFF);
    wr_reg(2'd1, 32'hFF00_FF00, '0);
    wr_reg(2'd2, 32'hF0F0_F0F0, '0);
    rd_chk(2'd3, "R7 R8 pending mixed");
    check("R7 value", rdata_a, 32'h0F00_0F00);
    check("R8 value", rdata_b, 32'hFF0F_FF0F);
    wr_reg(2'd1, 32'h0000_0000, '0);
    wr_reg(2'd2, 32'hFFFF_FFFF, '0);
    rd_chk(2'd3, "R7 R8 all gated");
    @(negedge clk);
    check("R10 irq low when nothing pending", {31'd0, irq_a | irq_b}, '0);
    wr_reg(2'd1, 32'h8000_0000, '0);
    @(negedge clk);
    check("R8 enable over mask raises irq", {31'd0, irq_b}, 32'd1);
    check("R7 mask blocks irq", {31'd0, irq_a}, '0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0; evt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rw();
    t_event();
    t_w1c();
    t_pend_ro();
    t_priority();
    finish_run();
  end
endmodule